// File: doc/BRIEF.md
# Dual Accumulator Register File

This block holds the two wide accumulators that a multiply-accumulate unit of an integer core works on. A write port loads a complete 64-bit value into one of the two accumulators. A select port reads one accumulator back, and a second, dedicated path always presents accumulator 0. The multiply-accumulate arithmetic, saturation and rounding live outside the block.

Both read paths treat an accumulator as a signed 56-bit quantity. The stored value keeps all 64 bits, but each read keeps bits 55:0 and fills bits 63:56 with copies of bit 55. The top byte that was written is therefore never visible. The sign extension is built by masking to 56 bits, flipping bit 55, and then subtracting a value that has only bit 55 set.

Top module: `dual_acc`

## Requirements
- R1: While rst_ni is low, both accumulators are cleared, so both read paths return 0.
- R2: A select value of 0 addresses accumulator 0. Any nonzero select value (1, 2 or 3) addresses accumulator 1. This holds for writes and for reads.
- R3: After a write, the addressed accumulator returns bits 55:0 of the written value unchanged.
- R4: Bits 63:56 of every read result are copies of bit 55 of that result, whatever top byte was written.
- R5: acc0_data_o always returns accumulator 0, sign-extended as in R4, independent of rd_sel_i.
- R6: A write takes effect at the rising clock edge. A read in the same cycle as a write to the same accumulator returns the old contents, and the new contents appear after that edge.
- R7: With wr_en_i low, neither accumulator changes, whatever wr_sel_i and wr_data_i carry.
- R8: A write to one accumulator leaves the other accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 selects accumulator 0, nonzero selects accumulator 1 |
| wr_data_i | input | 64 | Value to store |
| rd_sel_i | input | 2 | Read target: 0 selects accumulator 0, nonzero selects accumulator 1 |
| rd_data_o | output | 64 | Selected accumulator, sign-extended from bit 55 |
| acc0_data_o | output | 64 | Accumulator 0, sign-extended from bit 55 |

## Verification
Each write value is chosen with a different top byte and bit 55. Positive values with a non-sign top byte show that the stored top byte is hidden. Values with bit 55 set show that the upper byte is filled with ones. The all-ones and all-zeros corners show that the mask and the subtraction do not borrow into the wrong bits. The select values 2 and 3 separate a decoder that treats any nonzero value as accumulator 1 from one that compares against 1. Interleaved writes to the two accumulators show that one cannot disturb the other. A write and a read in the same cycle show that the read returns the value from before the edge.

// File: rtl/dual_acc_pkg.sv
package dual_acc_pkg;
  localparam int unsigned ACC_W_DEF = 64;
  localparam int unsigned SIG_W_DEF = 56;
  localparam int unsigned SEL_W_DEF = 2;
  localparam int unsigned NUM_ACC   = 2;
endpackage

// File: rtl/acc_sext.sv
// Sign-extend the low SIG_W bits of a word: mask, flip sign, subtract sign weight.
module acc_sext #(
  parameter int unsigned ACC_W = 64,
  parameter int unsigned SIG_W = 56
) (
  input  logic [ACC_W-1:0] val_i,
  output logic [ACC_W-1:0] ext_o
);
  localparam logic [ACC_W-1:0] MASK = {{(ACC_W-SIG_W){1'b0}}, {SIG_W{1'b1}}};
  localparam logic [ACC_W-1:0] SIGN = {{(ACC_W-SIG_W){1'b0}}, 1'b1, {(SIG_W-1){1'b0}}};

  logic [ACC_W-1:0] flip;

  always_comb begin
    flip  = (val_i & MASK) ^ SIGN;
    ext_o = flip - SIGN;
  end
endmodule

// File: rtl/acc_bank.sv
module acc_bank
  import dual_acc_pkg::*;
#(
  parameter int unsigned ACC_W = 64,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [ACC_W-1:0] wr_data_i,
  output logic [ACC_W-1:0] acc_o [NUM_ACC]
);
  // nonzero select collapses onto accumulator 1
  logic wr_idx;
  assign wr_idx = |wr_sel_i;

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    logic [ACC_W-1:0] acc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q <= '0;
      end else if (wr_en_i && (wr_idx == 1'(g))) begin
        acc_q <= wr_data_i;
      end
    end
    assign acc_o[g] = acc_q;
  end
endmodule

// File: rtl/dual_acc.sv
module dual_acc
  import dual_acc_pkg::*;
#(
  parameter int unsigned ACC_W = ACC_W_DEF,
  parameter int unsigned SIG_W = SIG_W_DEF,
  parameter int unsigned SEL_W = SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [ACC_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [ACC_W-1:0] rd_data_o,
  output logic [ACC_W-1:0] acc0_data_o
);
  logic [ACC_W-1:0] acc [NUM_ACC];
  logic [ACC_W-1:0] raw [2];
  logic [ACC_W-1:0] ext [2];

  acc_bank #(
    .ACC_W(ACC_W),
    .SEL_W(SEL_W)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .acc_o    (acc)
  );

  // path 0: selected read, path 1: fixed accumulator 0
  assign raw[0] = (|rd_sel_i) ? acc[1] : acc[0];
  assign raw[1] = acc[0];

  for (genvar p = 0; p < 2; p++) begin : g_rd
    acc_sext #(
      .ACC_W(ACC_W),
      .SIG_W(SIG_W)
    ) u_sext (
      .val_i(raw[p]),
      .ext_o(ext[p])
    );
  end

  assign rd_data_o   = ext[0];
  assign acc0_data_o = ext[1];
endmodule

// File: rtl/dual_acc_chk.sv
module dual_acc_chk #(
  parameter int unsigned ACC_W = 64,
  parameter int unsigned SIG_W = 56,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [SEL_W-1:0] wr_sel_i,
  input logic [SIG_W-1:0] wr_low_i,
  input logic [SEL_W-1:0] rd_sel_i,
  input logic [ACC_W-1:0] rd_data_o,
  input logic [ACC_W-1:0] acc0_data_o
);
  localparam int unsigned TOP_W = ACC_W - SIG_W;

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (rd_data_o == '0 && acc0_data_o == '0));

  a_r4_top_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[ACC_W-1:SIG_W] == {TOP_W{rd_data_o[SIG_W-1]}});

  a_r5_sel0_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == '0) |-> (rd_data_o == acc0_data_o));

  a_r6_acc0_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == '0) |=> (acc0_data_o[SIG_W-1:0] == $past(wr_low_i)));

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(acc0_data_o));

  a_r8_acc1_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i != '0) |=> $stable(acc0_data_o));
endmodule

bind dual_acc dual_acc_chk #(
  .ACC_W(ACC_W),
  .SIG_W(SIG_W),
  .SEL_W(SEL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_low_i   (wr_data_i[SIG_W-1:0]),
  .rd_sel_i   (rd_sel_i),
  .rd_data_o  (rd_data_o),
  .acc0_data_o(acc0_data_o)
);

// File: tb/dual_acc_tb_top.sv
module dual_acc_tb_top;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [1:0]  sel;
    logic [63:0] data;
    logic [63:0] exp;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{sel: 2'd0, data: 64'hAB12_3456_789A_BCDE, exp: 64'h0012_3456_789A_BCDE},
    '{sel: 2'd1, data: 64'h0080_0000_0000_0001, exp: 64'hFF80_0000_0000_0001},
    '{sel: 2'd2, data: 64'h7FFF_FFFF_FFFF_FFFF, exp: 64'hFFFF_FFFF_FFFF_FFFF},
    '{sel: 2'd3, data: 64'hFF7F_FFFF_FFFF_FFFF, exp: 64'h007F_FFFF_FFFF_FFFF},
    '{sel: 2'd0, data: 64'h0000_0000_0000_0000, exp: 64'h0000_0000_0000_0000},
    '{sel: 2'd0, data: 64'hC0DE_0000_0000_FACE, exp: 64'hFFDE_0000_0000_FACE}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [63:0] rd_data;
  logic [63:0] acc0_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_acc dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .rd_sel_i   (rd_sel),
    .rd_data_o  (rd_data),
    .acc0_data_o(acc0_data)
  );

  function automatic logic [63:0] sx(input logic [63:0] v);
    return {{8{v[55]}}, v[55:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_sel(input logic [1:0] sel, output logic [63:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  initial begin
    logic [63:0] v;
    logic [63:0] m0;
    logic [63:0] m1;
    m0 = '0; m1 = '0;

    // R1: reset state
    #(CLK_PERIOD*2 + 1);
    read_sel(2'd0, v); check("R1 acc0 rd", v, 64'h0);
    read_sel(2'd1, v); check("R1 acc1 rd", v, 64'h0);
    check("R1 acc0 path", acc0_data, 64'h0);
    rst_n = 1'b1;

    // vector table: R2 R3 R4 R5 R8
    for (int i = 0; i < NVEC; i++) begin
      do_write(VECS[i].sel, VECS[i].data);
      if (VECS[i].sel == 2'd0) m0 = VECS[i].data; else m1 = VECS[i].data;
      read_sel(VECS[i].sel, v);
      check("R2 R3 R4 vector read", v, VECS[i].exp);
      check("R5 R8 acc0 path", acc0_data, sx(m0));
      read_sel((VECS[i].sel == 2'd0) ? 2'd3 : 2'd0, v);
      check("R8 other acc", v, (VECS[i].sel == 2'd0) ? sx(m1) : sx(m0));
    end

    // R5: acc0 path independent of rd_sel
    do_write(2'd2, 64'h1111_2222_3333_4444); m1 = 64'h1111_2222_3333_4444;
    read_sel(2'd1, v);
    check("R5 acc0 path with rd_sel=1", acc0_data, sx(m0));
    check("R2 acc1 via sel1", v, sx(m1));

    // R7: disabled write ignored
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = 64'h0055_AAAA_5555_AAAA;
    @(negedge clk);
    wr_sel = 2'd1;
    @(negedge clk);
    read_sel(2'd0, v); check("R7 acc0 held", v, sx(m0));
    read_sel(2'd1, v); check("R7 acc1 held", v, sx(m1));

    // R6: same-cycle read returns old, new after edge
    @(negedge clk);
    rd_sel = 2'd0;
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 64'h0012_0000_0000_0077;
    #1;
    check("R6 old on same cycle", rd_data, sx(m0));
    m0 = 64'h0012_0000_0000_0077;
    @(negedge clk);
    wr_en = 1'b0;
    check("R6 new after edge", rd_data, sx(m0));

    // R1: reset mid-run clears both
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    read_sel(2'd0, v); check("R1 async clear acc0", v, 64'h0);
    read_sel(2'd3, v); check("R1 async clear acc1", v, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule